// File: doc/BRIEF.md
# Earliest-Completion Event Scheduler

This block holds a small table of pipeline-stage slots for a discrete-event model of an asynchronous instruction pipeline. Every slot is idle, busy or blocked, and a busy slot carries the time left until its current instruction finishes. When a step is requested, the block picks the busy slot that finishes first. It adds that slot's remaining time to a global time counter and takes the same amount off every other busy slot. The index of the chosen slot is reported so that surrounding logic can retire the instruction or move it on.

Surrounding logic fills a slot through a load port, which writes a finish time and makes the slot busy. It changes a slot's condition through a state port, for example to mark it blocked while its successor is occupied and to release it later. The selection is made over the table as it stands before the step edge. Writes arriving in the same cycle as a step are applied on top of the step's result.

Top module: `evsched_top`

## Requirements
- R1: After reset every slot is idle with zero remaining time, the global time reads 0, and `res_valid`, `res_empty` are low.
- R2: Only busy slots (state code 2'b01) take part in the selection. Idle (2'b00) and blocked (2'b10) slots are never reported as the winner.
- R3: The winner is the busy slot with the smallest remaining time. When several busy slots share that time, the one with the highest index wins.
- R4: On a step with a winner, the global time grows by the winner's remaining time. It saturates at all ones (2^GT_W-1) instead of wrapping.
- R5: On a step with a winner, every other busy slot loses exactly the winner's remaining time. The winner itself becomes idle with zero remaining time.
- R6: A blocked slot keeps its remaining time through any number of steps. Setting it busy again resumes with that stored time.
- R7: A load writes the slot's remaining time and makes it busy. A load to a slot in the same cycle as a step overrides that step's effect on the slot, and it also overrides a state write to the same slot.
- R8: The state port writes code 2'b00 idle, 2'b01 busy or 2'b10 blocked and leaves the remaining time untouched. Code 2'b11 is ignored and the slot keeps its state.
- R9: A one-cycle `step_req` produces `res_valid` high for exactly one cycle, starting one cycle later, together with `res_idx` and `res_delta`. `res_valid` is low in cycles that follow no request.
- R10: A step with no busy slot raises `res_empty` with `res_valid`, reports index 0 and delta 0, and changes neither the slots nor the global time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req | input | 1 | One-cycle request to process the next event |
| load_en | input | 1 | Load a remaining time into a slot |
| load_idx | input | IW | Slot addressed by the load |
| load_time | input | TW | Remaining time written by the load |
| st_en | input | 1 | Write a slot state |
| st_idx | input | IW | Slot addressed by the state write |
| st_val | input | 2 | State code (00 idle, 01 busy, 10 blocked, 11 ignored) |
| res_valid | output | 1 | Step result valid, one cycle after the request |
| res_empty | output | 1 | The step found no busy slot |
| res_idx | output | IW | Index of the winning slot |
| res_delta | output | TW | Time applied by the step |
| gtime | output | GT_W | Global time counter |

## Verification
The step and a load can land on the same slot in the same cycle. The bench provokes this by raising `step_req` and `load_en` together, once aimed at the slot that is about to win and once at a slot that would otherwise be decremented. It judges the outcome by the following step deltas. The loaded value must come back intact, never reduced by the concurrent event, while the reported winner and delta still reflect the table as it stood before the edge. The saturating time counter is exercised on a narrowed counter width, so the clamp is reached within a few steps.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_BUSY    = 2'b01,
    ST_BLOCKED = 2'b10
  } slot_state_e;

  function automatic logic code_legal(input logic [1:0] code);
    return code != 2'b11;
  endfunction
endpackage

// File: rtl/evsched_minsel.sv
module evsched_minsel #(
  parameter int N  = 8,
  parameter int TW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy_i,
  input  logic [TW-1:0] times_i [N],
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [TW-1:0] min_o
);
  // Scan from the top index down; strict less-than keeps the higher index on ties.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    min_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (busy_i[i] && (!found_o || times_i[i] < min_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        min_o   = times_i[i];
      end
    end
  end
endmodule

// File: rtl/evsched_slot.sv
module evsched_slot
  import evsched_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_fire_i,
  input  logic          is_win_i,
  input  logic [TW-1:0] delta_i,
  input  logic          ld_i,
  input  logic [TW-1:0] ld_time_i,
  input  logic          sw_i,
  input  logic [1:0]    sw_val_i,
  output slot_state_e   state_o,
  output logic [TW-1:0] time_o
);
  slot_state_e   state_q, state_d;
  logic [TW-1:0] time_q, time_d;
  logic          ev_hit;

  assign ev_hit = step_fire_i && state_q == ST_BUSY;

  always_comb begin
    state_d = state_q;
    time_d  = time_q;
    if (ev_hit) begin
      if (is_win_i) begin
        state_d = ST_IDLE;
        time_d  = '0;
      end else begin
        time_d = time_q - delta_i;
      end
    end
    if (sw_i && code_legal(sw_val_i)) state_d = slot_state_e'(sw_val_i);
    if (ld_i) begin
      state_d = ST_BUSY;
      time_d  = ld_time_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      time_q  <= '0;
    end else begin
      state_q <= state_d;
      time_q  <= time_d;
    end
  end

  assign state_o = state_q;
  assign time_o  = time_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> time_q >= delta_i); // R5
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED && !ld_i) |=> $stable(time_q)); // R6
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (state_q == ST_BUSY && time_q == $past(ld_time_i))); // R7
  AST_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_i && sw_val_i == 2'b11 && !ld_i && !ev_hit) |=> $stable(state_q)); // R8
endmodule

// File: rtl/evsched_gclock.sv
module evsched_gclock #(
  parameter int TW   = 16,
  parameter int GT_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic [TW-1:0]   delta_i,
  output logic [GT_W-1:0] gtime_o
);
  localparam logic [GT_W-1:0] GMAX = '1;

  function automatic logic [GT_W-1:0] sat_add(input logic [GT_W-1:0] a,
                                              input logic [TW-1:0] d);
    logic [GT_W:0] s;
    s = {1'b0, a} + (GT_W + 1)'(d);
    return s[GT_W] ? GMAX : s[GT_W-1:0];
  endfunction

  logic [GT_W-1:0] gtime_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gtime_q <= '0;
    else if (adv_i) gtime_q <= sat_add(gtime_q, delta_i);
  end

  assign gtime_o = gtime_q;

  AST_GTIME_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> gtime_q >= $past(gtime_q)); // R4
  AST_GTIME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(gtime_q)); // R10
endmodule

// File: rtl/evsched_top.sv
module evsched_top
  import evsched_pkg::*;
#(
  parameter int N    = 8,
  parameter int TW   = 16,
  parameter int GT_W = 32,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_req,
  input  logic            load_en,
  input  logic [IW-1:0]   load_idx,
  input  logic [TW-1:0]   load_time,
  input  logic            st_en,
  input  logic [IW-1:0]   st_idx,
  input  logic [1:0]      st_val,
  output logic            res_valid,
  output logic            res_empty,
  output logic [IW-1:0]   res_idx,
  output logic [TW-1:0]   res_delta,
  output logic [GT_W-1:0] gtime
);
  slot_state_e   slot_st [N];
  logic [TW-1:0] slot_tm [N];
  logic [N-1:0]  busy_vec;
  logic          sel_found;
  logic [IW-1:0] sel_idx;
  logic [TW-1:0] sel_min;
  logic          step_fire;

  assign step_fire = step_req && sel_found;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign busy_vec[g] = slot_st[g] == ST_BUSY;
    evsched_slot #(.TW(TW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_fire_i(step_fire),
      .is_win_i   (sel_idx == IW'(g)),
      .delta_i    (sel_min),
      .ld_i       (load_en && load_idx == IW'(g)),
      .ld_time_i  (load_time),
      .sw_i       (st_en && st_idx == IW'(g)),
      .sw_val_i   (st_val),
      .state_o    (slot_st[g]),
      .time_o     (slot_tm[g])
    );
  end

  evsched_minsel #(.N(N), .TW(TW), .IW(IW)) u_minsel (
    .busy_i (busy_vec),
    .times_i(slot_tm),
    .found_o(sel_found),
    .idx_o  (sel_idx),
    .min_o  (sel_min)
  );

  evsched_gclock #(.TW(TW), .GT_W(GT_W)) u_gclock (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (step_fire),
    .delta_i(sel_min),
    .gtime_o(gtime)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_empty <= 1'b0;
      res_idx   <= '0;
      res_delta <= '0;
    end else begin
      res_valid <= step_req;
      res_empty <= step_req && !sel_found;
      res_idx   <= step_fire ? sel_idx : '0;
      res_delta <= step_fire ? sel_min : '0;
    end
  end

  AST_WIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found |-> busy_vec[sel_idx]); // R2
  AST_FOUND_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_found == (busy_vec != '0)); // R2
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> res_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_req |=> !res_valid); // R9
  AST_EMPTY_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !sel_found) |=> (res_empty && res_delta == '0 && $stable(gtime))); // R10
endmodule

// File: tb/evsched_top_tb_top.sv
module evsched_top_tb_top;
  localparam int N    = 8;
  localparam int TW   = 16;
  localparam int GT_W = 20;
  localparam int IW   = 3;
  localparam longint GMAX = (64'd1 << GT_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            step_req = 1'b0;
  logic            load_en = 1'b0;
  logic [IW-1:0]   load_idx = '0;
  logic [TW-1:0]   load_time = '0;
  logic            st_en = 1'b0;
  logic [IW-1:0]   st_idx = '0;
  logic [1:0]      st_val = '0;
  logic            res_valid, res_empty;
  logic [IW-1:0]   res_idx;
  logic [TW-1:0]   res_delta;
  logic [GT_W-1:0] gtime;

  int     checks = 0;
  int     failures = 0;
  longint exp_g = 0;
  bit     done = 1'b0;

  always #5 clk = ~clk;

  evsched_top #(.N(N), .TW(TW), .GT_W(GT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_req(step_req),
    .load_en(load_en), .load_idx(load_idx), .load_time(load_time),
    .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
    .res_valid(res_valid), .res_empty(res_empty), .res_idx(res_idx),
    .res_delta(res_delta), .gtime(gtime)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_g = 0;
  endtask

  task automatic load(input int idx, input int t);
    @(negedge clk);
    load_en = 1'b1; load_idx = IW'(idx); load_time = TW'(t);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic set_st(input int idx, input logic [1:0] v);
    @(negedge clk);
    st_en = 1'b1; st_idx = IW'(idx); st_val = v;
    @(negedge clk);
    st_en = 1'b0;
  endtask

  // Step and check winner/delta; the expected global time follows saturating addition.
  task automatic step_expect(input string req, input int idx, input int d);
    @(negedge clk);
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    exp_g = exp_g + d;
    if (exp_g > GMAX) exp_g = GMAX;
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_empty", res_empty, 0);
    chk(req, "res_idx", res_idx, idx);
    chk(req, "res_delta", res_delta, d);
    chk(req, "gtime", gtime, exp_g);
  endtask

  task automatic step_empty(input string req);
    @(negedge clk);
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    chk(req, "res_valid", res_valid, 1);
    chk(req, "res_empty", res_empty, 1);
    chk(req, "res_idx", res_idx, 0);
    chk(req, "res_delta", res_delta, 0);
    chk(req, "gtime", gtime, exp_g);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "gtime", gtime, 0);
    chk("R1", "res_valid", res_valid, 0);
    chk("R1", "res_empty", res_empty, 0);
    step_empty("R1_R10");
    @(negedge clk);
    chk("R9", "res_valid low after pulse", res_valid, 0);
  endtask

  task automatic t_order();
    load(2, 40); load(5, 25); load(7, 60);
    step_expect("R3", 5, 25);
    step_expect("R5", 2, 15);
    step_expect("R5", 7, 20);
    step_empty("R10");
  endtask

  task automatic t_tie();
    load(1, 10); load(6, 10); load(3, 10);
    step_expect("R3", 6, 10);
    step_expect("R3", 3, 0);
    step_expect("R3", 1, 0);
  endtask

  task automatic t_blocked();
    load(0, 30); load(4, 12);
    set_st(0, 2'b10);
    load(2, 5);
    step_expect("R6", 2, 5);
    step_expect("R2", 4, 7);
    step_empty("R2");
    set_st(0, 2'b01);
    step_expect("R6", 0, 30);
  endtask

  task automatic t_codes();
    load(3, 9);
    set_st(3, 2'b11);
    step_expect("R8", 3, 9);
    load(5, 4);
    set_st(5, 2'b00);
    load(6, 8);
    step_expect("R8", 6, 8);
    step_empty("R8");
  endtask

  task automatic t_collide();
    load(1, 20); load(2, 50);
    @(negedge clk);
    step_req = 1'b1; load_en = 1'b1; load_idx = 3'd1; load_time = 16'd100;
    @(negedge clk);
    step_req = 1'b0; load_en = 1'b0;
    exp_g += 20;
    chk("R7", "winner idx", res_idx, 1);
    chk("R7", "winner delta", res_delta, 20);
    step_expect("R7", 2, 30);
    step_expect("R7", 1, 70);
    load(4, 5); load(5, 9);
    @(negedge clk);
    step_req = 1'b1; load_en = 1'b1; load_idx = 3'd5; load_time = 16'd50;
    st_en = 1'b1; st_idx = 3'd5; st_val = 2'b10;
    @(negedge clk);
    step_req = 1'b0; load_en = 1'b0; st_en = 1'b0;
    exp_g += 5;
    chk("R7", "winner idx", res_idx, 4);
    step_expect("R7", 5, 50);
  endtask

  task automatic t_sat();
    do_reset();
    for (int k = 0; k < 17; k++) begin
      load(0, 16'hFFFF);
      step_expect("R4", 0, 65535);
      if (k == 15) chk("R4", "pre-saturation gtime", gtime, 1048560);
    end
    chk("R4", "saturated gtime", gtime, GMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_tie();
    t_blocked();
    t_codes();
    t_collide();
    t_sat();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule